// File: doc/BRIEF.md
# Filtered Time-Tagged Serial Word Receiver

This block is one receive channel for 32-bit avionics serial words. A line decoder upstream hands it each complete word together with a one-cycle valid strobe. The channel checks the word's odd parity and takes its 8-bit label field, bit-reversed, as an index into a 256-entry store/drop bitmap. It then decides whether the word is kept. A kept word leaves as one wide record on a write port toward buffer memory. The record holds the word itself, a 32-bit time tag and a status word, and it is written at the current pointer of a circular window.

A host-side write port sets up the channel. Through it the host loads the window limits, the bitmap, the run and wrap controls, and an optional start label that holds off storage until that label is seen. It also sets a threshold for a one-shot word-count interrupt and a period for a repeating interval interrupt. A write to a dedicated address clears the free-running time tag. The current pointer, the stored-word count and the overflow flag are outputs, so the host can poll them.

Top module: `rx_label_logger`

## Requirements
- R1: While reset is held and after it is released, rec_we, ovf, irq_cnt and irq_ivl are 0 and cur_ptr and word_cnt are 0.
- R2: A word presented with word_valid that is accepted appears on rec_data with rec_we high in the cycle after the strobe.
- R3: The filter index is word_in[7:0] bit-reversed (index bit 7 is word_in[0]). A word is stored only when its filter bit is 1. All filter bits are 0 after reset. A dropped word leaves rec_we low and cur_ptr unchanged.
- R4: Expected parity is odd over all 32 bits. rec_stat bit 0 is 1 when the word holds an even number of ones, and that word is still stored.
- R5: The time tag increments by one every clock and returns to 0 after a write to address 7. rec_tag carries the tag value of the cycle in which the word was strobed.
- R6: Records are written at cur_ptr, which then steps by one. When wrap is enabled, a write at the end pointer sends cur_ptr back to the start pointer.
- R7: When wrap is disabled, a write at the end pointer sets ovf and leaves cur_ptr there. While ovf is set, all words are dropped. Only a write to the start address clears ovf.
- R8: When start-trigger is enabled, words are dropped until a word whose filter index equals the trigger label arrives. That word and later words follow the filter. A stored trigger word has rec_stat bit 1 set.
- R9: word_cnt counts stored words. irq_cnt pulses for one cycle, together with the record that brings the count equal to a nonzero threshold. A threshold of 0 disables it.
- R10: irq_ivl pulses together with every Nth stored record, where N is a nonzero interval length. 0 disables it.
- R11: With the run bit clear, no word is stored.
- R12: Host write addresses are as follows. Address 0 is control: bit 0 run, bit 1 wrap, bit 2 start-trigger enable. Address 1 is the start pointer; a write there also loads cur_ptr and clears word count, interval count, ovf and the trigger state. Address 2 is the end pointer. Address 3 is the trigger label index. Address 4 is the count threshold. Address 5 is the interval length. Address 6 is a filter entry: bits 7:0 index, bit 8 value. Address 7 clears the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | One-cycle strobe for a decoded word |
| word_in | input | 32 | Decoded serial word |
| hst_we | input | 1 | Host register write strobe |
| hst_addr | input | 3 | Host register address |
| hst_wdata | input | 32 | Host write data |
| rec_we | output | 1 | Record write enable |
| rec_addr | output | AW | Record slot address |
| rec_data | output | 32 | Stored word |
| rec_tag | output | 32 | Time tag of the stored word |
| rec_stat | output | 32 | Status word (bit 0 parity error, bit 1 trigger word) |
| cur_ptr | output | AW | Current buffer pointer |
| word_cnt | output | CW | Stored word count |
| ovf | output | 1 | Buffer overflow, sticky |
| irq_cnt | output | 1 | Word-count trigger pulse |
| irq_ivl | output | 1 | Interval trigger pulse |

## Verification
The main sweep sends one word for each of the 256 raw label values against a filter that keeps every third index. Only a correct bit reversal puts the stored records at the expected labels. The data bytes are derived from the label, so parity alternates unevenly and status bit 0 is separated from the data path. The 8-slot wrapping window is crossed about ten times during the sweep, and the count threshold of 7 and interval of 5 fall on different records, so pointer wrap, the one-shot trigger and the periodic trigger each show an off-by-one on its own. A second pattern in a 4-slot non-wrapping window with a start label shows the hold-off, the trigger-word status bit, the overflow stop and its clearance. Idle gaps before a strobe fix the time tag value.

// File: rtl/rx_logger_pkg.sv
package rx_logger_pkg;
  localparam int WORD_W = 32;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_START = 3'd1;
  localparam logic [2:0] REG_END   = 3'd2;
  localparam logic [2:0] REG_TLBL  = 3'd3;
  localparam logic [2:0] REG_THR   = 3'd4;
  localparam logic [2:0] REG_IVL   = 3'd5;
  localparam logic [2:0] REG_FILT  = 3'd6;
  localparam logic [2:0] REG_TCLR  = 3'd7;

  localparam int ST_PERR = 0;
  localparam int ST_TRIG = 1;

  typedef struct packed {
    logic trig_en;
    logic wrap_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/rx_tag_counter.sv
module rx_tag_counter #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [TW-1:0] tag
);
  logic [TW-1:0] tag_d;

  always_comb begin
    tag_d = tag + TW'(1);
    if (clr) tag_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag <= '0;
    else        tag <= tag_d;
  end
endmodule

// File: rtl/rx_label_filter.sv
module rx_label_filter
  import rx_logger_pkg::*;
#(
  parameter int LBW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LBW-1:0]    wr_idx,
  input  logic              wr_val,
  input  logic [WORD_W-1:0] word,
  output logic [LBW-1:0]    idx,
  output logic              hit,
  output logic              perr
);
  localparam int DEPTH = 1 << LBW;

  logic [DEPTH-1:0] map_q, map_d;

  // label arrives most significant bit first in the lowest word bit
  for (genvar b = 0; b < LBW; b++) begin : g_rev
    assign idx[b] = word[LBW-1-b];
  end

  always_comb begin
    map_d = map_q;
    if (wr_en) map_d[wr_idx] = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end

  assign hit  = map_q[idx];
  assign perr = ~^word;
endmodule

// File: rtl/rx_buf_ptr.sv
module rx_buf_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [AW-1:0] load_ptr,
  input  logic [AW-1:0] start_ptr,
  input  logic [AW-1:0] end_ptr,
  input  logic          wrap_en,
  input  logic          adv,
  output logic [AW-1:0] cur,
  output logic          full
);
  logic [AW-1:0] cur_d;
  logic          full_d;

  always_comb begin
    cur_d  = cur;
    full_d = full;
    if (restart) begin
      cur_d  = load_ptr;
      full_d = 1'b0;
    end else if (adv) begin
      if (cur == end_ptr) begin
        if (wrap_en) cur_d  = start_ptr;
        else         full_d = 1'b1;
      end else begin
        cur_d = cur + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= '0;
      full <= 1'b0;
    end else begin
      cur  <= cur_d;
      full <= full_d;
    end
  end
endmodule

// File: rtl/rx_trig_unit.sv
module rx_trig_unit #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          stored,
  input  logic [CW-1:0] cnt_thr,
  input  logic [CW-1:0] ivl_len,
  output logic [CW-1:0] word_cnt,
  output logic          irq_cnt,
  output logic          irq_ivl
);
  logic [CW-1:0] cnt_inc, ivl_q, ivl_inc, cnt_d, ivl_d;
  logic          irq_cnt_d, irq_ivl_d;

  assign cnt_inc = word_cnt + CW'(1);
  assign ivl_inc = ivl_q + CW'(1);

  always_comb begin
    cnt_d     = word_cnt;
    ivl_d     = ivl_q;
    irq_cnt_d = 1'b0;
    irq_ivl_d = 1'b0;
    if (restart) begin
      cnt_d = '0;
      ivl_d = '0;
    end else if (stored) begin
      cnt_d     = cnt_inc;
      irq_cnt_d = (cnt_thr != '0) && (cnt_inc == cnt_thr);
      if (ivl_len != '0) begin
        if (ivl_inc == ivl_len) begin
          ivl_d     = '0;
          irq_ivl_d = 1'b1;
        end else begin
          ivl_d = ivl_inc;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_cnt <= '0;
      ivl_q    <= '0;
      irq_cnt  <= 1'b0;
      irq_ivl  <= 1'b0;
    end else begin
      word_cnt <= cnt_d;
      ivl_q    <= ivl_d;
      irq_cnt  <= irq_cnt_d;
      irq_ivl  <= irq_ivl_d;
    end
  end
endmodule

// File: rtl/rx_label_logger.sv
module rx_label_logger
  import rx_logger_pkg::*;
#(
  parameter int AW  = 8,
  parameter int CW  = 16,
  parameter int LBW = 8,
  parameter int TW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_in,
  input  logic              hst_we,
  input  logic [2:0]        hst_addr,
  input  logic [31:0]       hst_wdata,
  output logic              rec_we,
  output logic [AW-1:0]     rec_addr,
  output logic [WORD_W-1:0] rec_data,
  output logic [TW-1:0]     rec_tag,
  output logic [31:0]       rec_stat,
  output logic [AW-1:0]     cur_ptr,
  output logic [CW-1:0]     word_cnt,
  output logic              ovf,
  output logic              irq_cnt,
  output logic              irq_ivl
);
  logic [1:0]     sync_q;
  logic           rst_i_n;
  ctrl_t          ctrl_q, ctrl_d;
  logic [AW-1:0]  start_q, start_d, end_q, end_d;
  logic [LBW-1:0] tlbl_q, tlbl_d, idx;
  logic [CW-1:0]  thr_q, thr_d, ivl_q, ivl_d;
  logic           trigd_q, trigd_d;
  logic           restart, tag_clr, filt_we, hit, perr, lbl_match, gate_open, accept, trig_word;
  logic [TW-1:0]  tag_q;
  logic [31:0]    stat_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_i_n = sync_q[1];

  assign restart = hst_we && (hst_addr == REG_START);
  assign tag_clr = hst_we && (hst_addr == REG_TCLR);
  assign filt_we = hst_we && (hst_addr == REG_FILT);

  always_comb begin
    ctrl_d  = ctrl_q;
    start_d = start_q;
    end_d   = end_q;
    tlbl_d  = tlbl_q;
    thr_d   = thr_q;
    ivl_d   = ivl_q;
    if (hst_we) begin
      case (hst_addr)
        REG_CTRL:  ctrl_d  = ctrl_t'(hst_wdata[2:0]);
        REG_START: start_d = hst_wdata[AW-1:0];
        REG_END:   end_d   = hst_wdata[AW-1:0];
        REG_TLBL:  tlbl_d  = hst_wdata[LBW-1:0];
        REG_THR:   thr_d   = hst_wdata[CW-1:0];
        REG_IVL:   ivl_d   = hst_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  rx_tag_counter #(.TW(TW)) u_tag (
    .clk(clk), .rst_n(rst_i_n), .clr(tag_clr), .tag(tag_q)
  );

  rx_label_filter #(.LBW(LBW)) u_filt (
    .clk(clk), .rst_n(rst_i_n), .wr_en(filt_we), .wr_idx(hst_wdata[LBW-1:0]),
    .wr_val(hst_wdata[LBW]), .word(word_in), .idx(idx), .hit(hit), .perr(perr)
  );

  assign lbl_match = (idx == tlbl_q);
  assign trig_word = ctrl_q.trig_en && !trigd_q && lbl_match;
  assign gate_open = !ctrl_q.trig_en || trigd_q || lbl_match;
  assign accept    = word_valid && ctrl_q.run && hit && !ovf && gate_open && !restart;

  always_comb begin
    trigd_d = trigd_q;
    if (restart) trigd_d = 1'b0;
    else if (word_valid && ctrl_q.run && trig_word) trigd_d = 1'b1;
    stat_d          = '0;
    stat_d[ST_PERR] = perr;
    stat_d[ST_TRIG] = trig_word;
  end

  rx_buf_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_i_n), .restart(restart), .load_ptr(hst_wdata[AW-1:0]),
    .start_ptr(start_q), .end_ptr(end_q), .wrap_en(ctrl_q.wrap_en), .adv(accept),
    .cur(cur_ptr), .full(ovf)
  );

  rx_trig_unit #(.CW(CW)) u_trig (
    .clk(clk), .rst_n(rst_i_n), .restart(restart), .stored(accept),
    .cnt_thr(thr_q), .ivl_len(ivl_q), .word_cnt(word_cnt),
    .irq_cnt(irq_cnt), .irq_ivl(irq_ivl)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q   <= '0;
      start_q  <= '0;
      end_q    <= '0;
      tlbl_q   <= '0;
      thr_q    <= '0;
      ivl_q    <= '0;
      trigd_q  <= 1'b0;
      rec_we   <= 1'b0;
      rec_addr <= '0;
      rec_data <= '0;
      rec_tag  <= '0;
      rec_stat <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      start_q <= start_d;
      end_q   <= end_d;
      tlbl_q  <= tlbl_d;
      thr_q   <= thr_d;
      ivl_q   <= ivl_d;
      trigd_q <= trigd_d;
      rec_we  <= accept;
      if (accept) begin
        rec_addr <= cur_ptr;
        rec_data <= word_in;
        rec_tag  <= tag_q;
        rec_stat <= stat_d;
      end
    end
  end
endmodule

// File: rtl/rx_logger_chk.sv
module rx_logger_chk #(
  parameter int TW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          word_valid,
  input logic          restart,
  input logic          tag_clr,
  input logic [TW-1:0] tag,
  input logic          rec_we,
  input logic          ovf,
  input logic          irq_cnt,
  input logic          irq_ivl
);
  AST_STORE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_we |-> $past(word_valid)); // R2
  AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_clr |=> tag == $past(tag) + TW'(1)); // R5
  AST_TAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tag_clr |=> tag == '0); // R5
  AST_NO_STORE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !restart |=> !rec_we); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !restart |=> ovf); // R7
  AST_CNT_IRQ_WITH_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cnt |-> rec_we); // R9
  AST_IVL_IRQ_WITH_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ivl |-> rec_we); // R10
endmodule

bind rx_label_logger rx_logger_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .word_valid(word_valid), .restart(restart),
  .tag_clr(tag_clr), .tag(tag_q), .rec_we(rec_we), .ovf(ovf),
  .irq_cnt(irq_cnt), .irq_ivl(irq_ivl)
);

// File: tb/test_rx_label_logger.sv
`timescale 1ns/1ps
module test_rx_label_logger;
  localparam int AW = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n, word_valid, hst_we;
  logic [31:0] word_in, hst_wdata;
  logic [2:0] hst_addr;
  logic rec_we, ovf, irq_cnt, irq_ivl;
  logic [AW-1:0] rec_addr, cur_ptr;
  logic [31:0] rec_data, rec_tag, rec_stat;
  logic [CW-1:0] word_cnt;

  always #4 clk = ~clk;

  rx_label_logger #(.AW(AW), .CW(CW)) i_rx_label_logger (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
    .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .rec_we(rec_we), .rec_addr(rec_addr), .rec_data(rec_data), .rec_tag(rec_tag),
    .rec_stat(rec_stat), .cur_ptr(cur_ptr), .word_cnt(word_cnt), .ovf(ovf),
    .irq_cnt(irq_cnt), .irq_ivl(irq_ivl)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // requirement-level model state
  logic [31:0] m_tag;
  bit filt_m [256];
  bit m_run, m_wrap, m_trig_en, m_trigd, m_full;
  logic [AW-1:0] m_start, m_end, m_cur;
  logic [7:0] m_tlbl;
  logic [15:0] m_thr, m_ivl, m_cnt, m_ivc;

  always @(posedge clk)
    if (hst_we && hst_addr == 3'd7) m_tag <= 32'd0;
    else m_tag <= m_tag + 32'd1;

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int b = 0; b < 8; b++) rev8[b] = v[7-b];
  endfunction

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_we = 1'b1; hst_addr = a; hst_wdata = d;
    case (a)
      3'd0: begin m_run = d[0]; m_wrap = d[1]; m_trig_en = d[2]; end
      3'd1: begin m_start = d[AW-1:0]; m_cur = d[AW-1:0]; m_cnt = 0; m_ivc = 0; m_full = 0; m_trigd = 0; end
      3'd2: m_end = d[AW-1:0];
      3'd3: m_tlbl = d[7:0];
      3'd4: m_thr = d[15:0];
      3'd5: m_ivl = d[15:0];
      3'd6: filt_m[d[7:0]] = d[8];
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic send(input logic [31:0] w, input string rq);
    logic [7:0] ix;
    bit lm, gate, acc, ic, ii;
    logic [31:0] est, etag;
    logic [AW-1:0] eaddr;
    ix = rev8(w[7:0]);
    lm = (ix == m_tlbl);
    gate = !m_trig_en || m_trigd || lm;
    acc = m_run && filt_m[ix] && !m_full && gate;
    est = {30'd0, m_trig_en && !m_trigd && lm, ~^w};
    if (m_run && m_trig_en && lm) m_trigd = 1;
    eaddr = m_cur; ic = 0; ii = 0;
    if (acc) begin
      m_cnt++;
      ic = (m_thr != 0) && (m_cnt == m_thr);
      if (m_ivl != 0) begin
        m_ivc++;
        if (m_ivc == m_ivl) begin m_ivc = 0; ii = 1; end
      end
      if (m_cur == m_end) begin
        if (m_wrap) m_cur = m_start; else m_full = 1;
      end else m_cur++;
    end
    word_valid = 1'b1; word_in = w; etag = m_tag;
    @(posedge clk);
    @(negedge clk);
    word_valid = 1'b0;
    check(rec_we == acc, {rq, " store decision"}, 32'(rec_we), 32'(acc));
    if (acc) begin
      check(rec_addr == eaddr, "R6 record address", 32'(rec_addr), 32'(eaddr));
      check(rec_data == w, "R2 record data", rec_data, w);
      check(rec_tag == etag, "R5 record tag", rec_tag, etag);
      check(rec_stat == est, "R4 R8 status word", rec_stat, est);
    end
    check(irq_cnt == ic, "R9 count irq", 32'(irq_cnt), 32'(ic));
    check(irq_ivl == ii, "R10 interval irq", 32'(irq_ivl), 32'(ii));
    check(ovf == m_full, "R7 overflow", 32'(ovf), 32'(m_full));
    check(cur_ptr == m_cur, "R6 current pointer", 32'(cur_ptr), 32'(m_cur));
    check(word_cnt == m_cnt, "R9 word count", 32'(word_cnt), 32'(m_cnt));
  endtask

  task automatic check_idle(input string rq);
    check(rec_we == 0 && ovf == 0 && irq_cnt == 0 && irq_ivl == 0, rq,
          {28'd0, rec_we, ovf, irq_cnt, irq_ivl}, 32'd0);
    check(cur_ptr == 0 && word_cnt == 0, rq, {8'd0, cur_ptr, word_cnt}, 32'd0);
  endtask

  initial begin
    #1200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; word_valid = 1'b0; word_in = '0;
    hst_we = 1'b0; hst_addr = '0; hst_wdata = '0;
    m_run = 0; m_wrap = 0; m_trig_en = 0; m_trigd = 0; m_full = 0;
    m_start = 0; m_end = 0; m_cur = 0; m_tlbl = 0; m_thr = 0; m_ivl = 0; m_cnt = 0; m_ivc = 0;
    for (int i = 0; i < 256; i++) filt_m[i] = 0;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 after reset");

    wr(3'd7, 32'd0);
    wr(3'd0, 32'd1);
    send(32'h1234_5601, "R3 empty filter");

    for (int i = 0; i < 256; i++) wr(3'd6, {23'd0, (i % 3) == 0, 8'(i)});
    wr(3'd1, 32'd16);
    check(cur_ptr == 16, "R12 start load", 32'(cur_ptr), 32'd16);
    wr(3'd2, 32'd23);
    wr(3'd4, 32'd7);
    wr(3'd5, 32'd5);
    wr(3'd0, 32'd3);
    for (int i = 0; i < 256; i++)
      send({8'(i) ^ 8'hA5, 8'(i * 7), 8'(i + 3), 8'(i)}, "R3 label sweep");

    wr(3'd7, 32'd0);
    repeat (9) @(negedge clk);
    send(32'h0F0F_0000, "R5 tag after clear");

    wr(3'd0, 32'd0);
    wr(3'd1, 32'd32);
    wr(3'd2, 32'd35);
    wr(3'd3, 32'd3);
    wr(3'd4, 32'd2);
    wr(3'd5, 32'd0);
    wr(3'd0, 32'd5);
    send({24'hABCDE0, rev8(8'd6)}, "R8 held off");
    send({24'h111111, rev8(8'd6)}, "R8 held off");
    send({24'h222222, rev8(8'd3)}, "R8 trigger word");
    for (int k = 0; k < 4; k++) send({8'(k), 16'h3C3C, rev8(8'd6)}, "R7 fill window");
    wr(3'd1, 32'd32);
    check(ovf == 0, "R7 overflow cleared", 32'(ovf), 32'd0);
    send({24'h555555, rev8(8'd3)}, "R8 rearmed trigger");

    wr(3'd0, 32'd2);
    send({24'h777777, rev8(8'd3)}, "R11 run clear");
    send({24'h777771, rev8(8'd6)}, "R11 run clear");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule